// File: doc/BRIEF.md
# Shared-Memory Multi-FIFO Manager

This block divides one single-port, word-wide memory into several circular queues. Queue 0 is the receive queue. Queues 1 to NUM_TX are transmit queues. Each queue owns a window of the memory, set by a start address and a depth. Each queue keeps its own write pointer, read pointer and fill count. One push port and one pop port each carry a queue index, so any queue can be written or read through them. At most one memory access happens per cycle.

Software sets the window of each queue while that queue is empty. The windows are meant to sit back to back: receive first, then transmit queue 0, then transmit queues 1, 2 and so on, each starting where the previous one ends. Two flush requests reset the pointers of queues. The transmit flush takes a queue number, and one reserved number selects every transmit queue at once. The receive flush is a separate request. Each flush shows a busy flag that clears itself when the pointer reset is complete. No push or pop is taken while either flag is set. The memory is modelled as a plain internal array.

Top module: `shared_fifo_mgr`

## Requirements
- R1: After reset every queue reports a level of 0, empty set, full clear (unless its depth is 0) and no error. Both flush busy flags are low, `rd_valid` is low, and `push_ready` and `pop_ready` are high while `pop_valid` is low.
- R2: Index 0 selects the receive queue and index k (1..NUM_TX) selects transmit queue k-1. A configuration write to an empty queue loads its start and depth. A configuration write to a queue that holds data is ignored and sets that queue's sticky error bit.
- R3: Words pop out of a queue in the order they were pushed. `rd_valid` rises, with the word on `rd_data`, in the cycle after a pop is accepted on a non-empty queue.
- R4: A queue pointer wraps from start+depth-1 back to start. Traffic on one queue never changes the words or the level of another queue.
- R5: A queue is full when its level equals its depth. A push to a full queue is ignored, leaves the level unchanged and sets the queue's sticky error bit.
- R6: A pop from an empty queue is ignored, gives no `rd_valid`, and sets the queue's sticky error bit.
- R7: If `pop_valid` is high, `push_ready` is low in that cycle, so the pop gets the memory port. A push held until the next cycle is then accepted.
- R8: A transmit flush with number n (0..NUM_TX-1) empties only transmit queue n (index n+1). All other queues keep their contents.
- R9: A transmit flush with number 0x10 empties every transmit queue and leaves the receive queue unchanged.
- R10: A receive flush empties only the receive queue.
- R11: A flush request raises its busy flag at the next clock edge. The flag stays high for exactly two cycles, and then the flushed queues are empty with their error bits cleared. While either flag is high, `push_ready` and `pop_ready` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | IDX_W | Queue chosen for configuration |
| cfg_start | input | ADDR_W | Window start address |
| cfg_depth | input | ADDR_W+1 | Window depth in words |
| push_valid | input | 1 | Push request |
| push_idx | input | IDX_W | Queue to push into |
| push_data | input | DATA_W | Word to push |
| push_ready | output | 1 | Push can be taken this cycle |
| pop_valid | input | 1 | Pop request |
| pop_idx | input | IDX_W | Queue to pop from |
| pop_ready | output | 1 | Pop can be taken this cycle |
| rd_valid | output | 1 | `rd_data` holds a popped word |
| rd_data | output | DATA_W | Popped word |
| tx_flush_req | input | 1 | Transmit flush request |
| tx_flush_num | input | 5 | Transmit queue number; 0x10 selects all |
| rx_flush_req | input | 1 | Receive flush request |
| tx_flush_busy | output | 1 | Transmit flush in progress; clears itself |
| rx_flush_busy | output | 1 | Receive flush in progress; clears itself |
| fifo_level | output | NQ*(ADDR_W+1) | Fill count per queue, queue q at bits q*(ADDR_W+1) |
| fifo_full | output | NQ | Full flag per queue |
| fifo_empty | output | NQ | Empty flag per queue |
| fifo_err | output | NQ | Sticky error flag per queue |

## Verification
The window assertions assume that every programmed window lies inside the memory, meaning start plus depth is at most 2^ADDR_W. They also assume that software never changes a window while traffic to that same queue arrives in the same cycle. The bench programs contiguous windows that fit in the first 24 words. It issues configuration writes only while no push or pop is active. Flush requests are raised only when no flush is busy, and never in the same cycle as push or pop traffic.

// File: rtl/sfm_pkg.sv
// Shared constants for the multi-FIFO manager.
// Assumes: NUM_TX stays below 16, so the all-queues code cannot collide with a queue number.
package sfm_pkg;
    localparam int FLUSH_NUM_W = 5;
    localparam logic [FLUSH_NUM_W-1:0] TX_ALL_CODE = 5'h10;
endpackage

// File: rtl/sfm_sram.sv
// Single-port memory model: one read or one write per cycle, with a registered read.
// Assumes: en and we come from a caller that never asks for two operations in one cycle.
module sfm_sram #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              en,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int WORDS = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [WORDS];

    // Write the word or register the addressed word.
    always_ff @(posedge clk) begin
        if (en && we) begin
            mem[addr] <= wdata;
        end else if (en) begin
            rdata <= mem[addr];
        end
    end
endmodule

// File: rtl/sfm_window.sv
// Pointer and level tracking for one queue window inside the shared memory.
// Assumes: start+depth fits in the memory, and at most one of push_en/pop_en is high per cycle.
module sfm_window #(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_start,
    input  logic [ADDR_W:0]   cfg_depth,
    input  logic              push_en,
    input  logic              pop_en,
    input  logic              flush,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [ADDR_W:0]   level,
    output logic              full,
    output logic              empty,
    output logic              err
);
    localparam int CNT_W = ADDR_W + 1;

    logic [ADDR_W-1:0] start_q, wr_q, rd_q, wr_nx, rd_nx;
    logic [CNT_W-1:0]  depth_q, cnt_q, end_pos;
    logic              err_q;

    // Compute the next pointers, wrapping at the window end.
    always_comb begin
        end_pos = CNT_W'(start_q) + depth_q;
        wr_nx = ((CNT_W'(wr_q) + CNT_W'(1)) == end_pos) ? start_q : wr_q + ADDR_W'(1);
        rd_nx = ((CNT_W'(rd_q) + CNT_W'(1)) == end_pos) ? start_q : rd_q + ADDR_W'(1);
    end

    assign full  = (cnt_q == depth_q);
    assign empty = (cnt_q == '0);

    // Update window, pointers, level and sticky error.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= '0;
            depth_q <= '0;
            wr_q    <= '0;
            rd_q    <= '0;
            cnt_q   <= '0;
            err_q   <= 1'b0;
        end else if (flush) begin
            wr_q  <= start_q;
            rd_q  <= start_q;
            cnt_q <= '0;
            err_q <= 1'b0;
        end else if (cfg_we && !empty) begin
            err_q <= 1'b1;
        end else if (cfg_we) begin
            start_q <= cfg_start;
            depth_q <= cfg_depth;
            wr_q    <= cfg_start;
            rd_q    <= cfg_start;
        end else if (push_en) begin
            if (full) begin
                err_q <= 1'b1;
            end else begin
                wr_q  <= wr_nx;
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end else if (pop_en) begin
            if (empty) begin
                err_q <= 1'b1;
            end else begin
                rd_q  <= rd_nx;
                cnt_q <= cnt_q - CNT_W'(1);
            end
        end
    end

    assign wr_addr = wr_q;
    assign rd_addr = rd_q;
    assign level   = cnt_q;
    assign err     = err_q;

    AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= depth_q); // R5
    AST_FULL_PUSH_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (push_en && full && !flush && !cfg_we) |=> ($stable(cnt_q) && err_q)); // R5
    AST_WR_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (depth_q != '0) |-> (wr_q >= start_q && CNT_W'(wr_q) < end_pos)); // R4
    AST_FLUSH_RESETS: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (cnt_q == '0 && wr_q == start_q && rd_q == start_q && !err_q)); // R11
endmodule

// File: rtl/sfm_flush_ctrl.sv
// Self-clearing flush sequencer for the transmit and receive queues.
// Assumes: requests that arrive while a flush of the same kind is busy may be dropped.
module sfm_flush_ctrl
    import sfm_pkg::*;
#(
    parameter int NUM_TX = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   tx_req,
    input  logic [FLUSH_NUM_W-1:0] tx_num,
    input  logic                   rx_req,
    output logic                   tx_busy,
    output logic                   rx_busy,
    output logic [NUM_TX:0]        clr_vec
);
    logic                   tx_busy_q, tx_ph_q, rx_busy_q, rx_ph_q;
    logic [FLUSH_NUM_W-1:0] num_q;

    // Two-cycle transmit flush sequence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_busy_q <= 1'b0;
            tx_ph_q   <= 1'b0;
            num_q     <= '0;
        end else if (!tx_busy_q && tx_req) begin
            tx_busy_q <= 1'b1;
            tx_ph_q   <= 1'b0;
            num_q     <= tx_num;
        end else if (tx_busy_q && !tx_ph_q) begin
            tx_ph_q <= 1'b1;
        end else if (tx_busy_q) begin
            tx_busy_q <= 1'b0;
            tx_ph_q   <= 1'b0;
        end
    end

    // Two-cycle receive flush sequence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_busy_q <= 1'b0;
            rx_ph_q   <= 1'b0;
        end else if (!rx_busy_q && rx_req) begin
            rx_busy_q <= 1'b1;
            rx_ph_q   <= 1'b0;
        end else if (rx_busy_q && !rx_ph_q) begin
            rx_ph_q <= 1'b1;
        end else if (rx_busy_q) begin
            rx_busy_q <= 1'b0;
            rx_ph_q   <= 1'b0;
        end
    end

    assign clr_vec[0] = rx_busy_q && rx_ph_q;
    for (genvar i = 0; i < NUM_TX; i++) begin : g_txsel
        assign clr_vec[i+1] = tx_busy_q && tx_ph_q &&
                              (num_q == TX_ALL_CODE || num_q == FLUSH_NUM_W'(i));
    end

    assign tx_busy = tx_busy_q;
    assign rx_busy = rx_busy_q;

    AST_TX_FLUSH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_busy_q) |=> tx_busy_q); // R11
    AST_TX_FLUSH_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_busy_q && $past(tx_busy_q)) |=> !tx_busy_q); // R11
    AST_RX_FLUSH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_busy_q) |=> rx_busy_q); // R11
    AST_RX_FLUSH_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_busy_q && $past(rx_busy_q)) |=> !rx_busy_q); // R11
endmodule

// File: rtl/shared_fifo_mgr.sv
// Top: one receive queue and NUM_TX transmit queues sharing a single-port memory.
// Assumes: windows are programmed contiguously and inside the memory; pop wins the port.
module shared_fifo_mgr
    import sfm_pkg::*;
#(
    parameter int NUM_TX = 3,
    parameter int ADDR_W = 6,
    parameter int DATA_W = 32,
    localparam int NQ    = NUM_TX + 1,
    localparam int IDX_W = $clog2(NQ),
    localparam int CNT_W = ADDR_W + 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_we,
    input  logic [IDX_W-1:0]       cfg_idx,
    input  logic [ADDR_W-1:0]      cfg_start,
    input  logic [CNT_W-1:0]       cfg_depth,
    input  logic                   push_valid,
    input  logic [IDX_W-1:0]       push_idx,
    input  logic [DATA_W-1:0]      push_data,
    output logic                   push_ready,
    input  logic                   pop_valid,
    input  logic [IDX_W-1:0]       pop_idx,
    output logic                   pop_ready,
    output logic                   rd_valid,
    output logic [DATA_W-1:0]      rd_data,
    input  logic                   tx_flush_req,
    input  logic [FLUSH_NUM_W-1:0] tx_flush_num,
    input  logic                   rx_flush_req,
    output logic                   tx_flush_busy,
    output logic                   rx_flush_busy,
    output logic [NQ*CNT_W-1:0]    fifo_level,
    output logic [NQ-1:0]          fifo_full,
    output logic [NQ-1:0]          fifo_empty,
    output logic [NQ-1:0]          fifo_err
);
    logic [ADDR_W-1:0] wr_arr [NQ];
    logic [ADDR_W-1:0] rd_arr [NQ];
    logic [NQ-1:0]     clr_vec;
    logic              busy, push_fire, pop_fire, push_ok, pop_ok, rd_valid_q;
    logic              mem_en, mem_we;
    logic [ADDR_W-1:0] mem_addr;

    sfm_flush_ctrl #(.NUM_TX(NUM_TX)) u_flush (
        .clk     (clk),
        .rst_n   (rst_n),
        .tx_req  (tx_flush_req),
        .tx_num  (tx_flush_num),
        .rx_req  (rx_flush_req),
        .tx_busy (tx_flush_busy),
        .rx_busy (rx_flush_busy),
        .clr_vec (clr_vec)
    );

    assign busy       = tx_flush_busy || rx_flush_busy;
    assign pop_ready  = !busy;
    assign push_ready = !busy && !pop_valid;
    assign pop_fire   = pop_valid && pop_ready;
    assign push_fire  = push_valid && push_ready;

    for (genvar q = 0; q < NQ; q++) begin : g_win
        sfm_window #(.ADDR_W(ADDR_W)) u_win (
            .clk       (clk),
            .rst_n     (rst_n),
            .cfg_we    (cfg_we && cfg_idx == IDX_W'(q)),
            .cfg_start (cfg_start),
            .cfg_depth (cfg_depth),
            .push_en   (push_fire && push_idx == IDX_W'(q)),
            .pop_en    (pop_fire && pop_idx == IDX_W'(q)),
            .flush     (clr_vec[q]),
            .wr_addr   (wr_arr[q]),
            .rd_addr   (rd_arr[q]),
            .level     (fifo_level[q*CNT_W +: CNT_W]),
            .full      (fifo_full[q]),
            .empty     (fifo_empty[q]),
            .err       (fifo_err[q])
        );
    end

    // Choose the single memory access for this cycle; a pop takes the port first.
    always_comb begin
        pop_ok   = pop_fire && (32'(pop_idx) < NQ) && !fifo_empty[pop_idx];
        push_ok  = push_fire && (32'(push_idx) < NQ) && !fifo_full[push_idx];
        mem_en   = pop_ok || push_ok;
        mem_we   = push_ok && !pop_ok;
        mem_addr = pop_ok ? rd_arr[pop_idx] : wr_arr[push_idx];
    end

    sfm_sram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
        .clk   (clk),
        .en    (mem_en),
        .we    (mem_we),
        .addr  (mem_addr),
        .wdata (push_data),
        .rdata (rd_data)
    );

    // Mark the cycle when read data from an accepted pop is on rd_data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid_q <= 1'b0;
        end else begin
            rd_valid_q <= pop_ok;
        end
    end
    assign rd_valid = rd_valid_q;

    AST_RD_FOLLOWS_POP: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(pop_valid && pop_ready)); // R3
    AST_POP_OWNS_PORT: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_valid && push_valid) |-> !push_ready); // R7
    AST_QUIET_IN_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_flush_busy || rx_flush_busy) |-> (!push_ready && !pop_ready)); // R11
endmodule

// File: tb/shared_fifo_mgr_test.sv
module shared_fifo_mgr_test;
    localparam int CLK_PERIOD = 10;
    localparam int NUM_TX = 3;
    localparam int ADDR_W = 6;
    localparam int DATA_W = 32;
    localparam int NQ = NUM_TX + 1;
    localparam int IDX_W = $clog2(NQ);
    localparam int CNT_W = ADDR_W + 1;

    logic clk = 1'b0;
    logic rst_n;
    logic cfg_we;
    logic [IDX_W-1:0] cfg_idx;
    logic [ADDR_W-1:0] cfg_start;
    logic [CNT_W-1:0] cfg_depth;
    logic push_valid;
    logic [IDX_W-1:0] push_idx;
    logic [DATA_W-1:0] push_data;
    logic push_ready;
    logic pop_valid;
    logic [IDX_W-1:0] pop_idx;
    logic pop_ready;
    logic rd_valid;
    logic [DATA_W-1:0] rd_data;
    logic tx_flush_req;
    logic [4:0] tx_flush_num;
    logic rx_flush_req;
    logic tx_flush_busy, rx_flush_busy;
    logic [NQ*CNT_W-1:0] fifo_level;
    logic [NQ-1:0] fifo_full, fifo_empty, fifo_err;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    shared_fifo_mgr #(.NUM_TX(NUM_TX), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) uut (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_start(cfg_start), .cfg_depth(cfg_depth),
        .push_valid(push_valid), .push_idx(push_idx), .push_data(push_data), .push_ready(push_ready),
        .pop_valid(pop_valid), .pop_idx(pop_idx), .pop_ready(pop_ready),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .tx_flush_req(tx_flush_req), .tx_flush_num(tx_flush_num), .rx_flush_req(rx_flush_req),
        .tx_flush_busy(tx_flush_busy), .rx_flush_busy(rx_flush_busy),
        .fifo_level(fifo_level), .fifo_full(fifo_full), .fifo_empty(fifo_empty), .fifo_err(fifo_err)
    );

    function automatic int lvl(input int q);
        return int'(fifo_level[q*CNT_W +: CNT_W]);
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic cfg(input int q, input int start, input int depth);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = IDX_W'(q);
        cfg_start = ADDR_W'(start); cfg_depth = CNT_W'(depth);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic push(input int q, input int data);
        @(negedge clk);
        push_valid = 1'b1; push_idx = IDX_W'(q); push_data = DATA_W'(data);
        @(negedge clk);
        push_valid = 1'b0;
    endtask

    task automatic pop_chk(input string req, input int q, input bit exp_v, input int exp_d);
        @(negedge clk);
        pop_valid = 1'b1; pop_idx = IDX_W'(q);
        @(negedge clk);
        pop_valid = 1'b0;
        chk(req, "rd_valid", int'(rd_valid), int'(exp_v));
        if (exp_v) chk(req, "rd_data", int'(rd_data), exp_d);
    endtask

    // Raise a flush, then follow the two busy cycles and the release.
    task automatic flush_seq(input string req, input bit is_tx, input int num);
        @(negedge clk);
        if (is_tx) begin tx_flush_req = 1'b1; tx_flush_num = 5'(num); end
        else rx_flush_req = 1'b1;
        @(negedge clk);
        tx_flush_req = 1'b0; rx_flush_req = 1'b0;
        chk("R11", "busy cycle 1", int'(is_tx ? tx_flush_busy : rx_flush_busy), 1);
        chk("R11", "push_ready in flush", int'(push_ready), 0);
        chk("R11", "pop_ready in flush", int'(pop_ready), 0);
        @(negedge clk);
        chk("R11", "busy cycle 2", int'(is_tx ? tx_flush_busy : rx_flush_busy), 1);
        @(negedge clk);
        chk(req, "busy cleared", int'(is_tx ? tx_flush_busy : rx_flush_busy), 0);
        chk("R11", "pop_ready after flush", int'(pop_ready), 1);
    endtask

    task automatic t_reset();
        for (int q = 0; q < NQ; q++) begin
            chk("R1", "level", lvl(q), 0);
            chk("R1", "empty", int'(fifo_empty[q]), 1);
            chk("R1", "err", int'(fifo_err[q]), 0);
        end
        chk("R1", "tx busy", int'(tx_flush_busy), 0);
        chk("R1", "rx busy", int'(rx_flush_busy), 0);
        chk("R1", "rd_valid", int'(rd_valid), 0);
        chk("R1", "push_ready", int'(push_ready), 1);
        chk("R1", "pop_ready", int'(pop_ready), 1);
    endtask

    task automatic t_config();
        cfg(0, 0, 8);
        cfg(1, 8, 4);
        cfg(2, 12, 4);
        cfg(3, 16, 8);
        for (int q = 0; q < NQ; q++) begin
            chk("R2", "full after cfg", int'(fifo_full[q]), 0);
            chk("R2", "err after cfg", int'(fifo_err[q]), 0);
        end
    endtask

    task automatic t_order();
        push(0, 32'hA1); push(0, 32'hB2); push(0, 32'hC3);
        chk("R3", "rx level", lvl(0), 3);
        pop_chk("R3", 0, 1'b1, 32'hA1);
        pop_chk("R3", 0, 1'b1, 32'hB2);
        pop_chk("R3", 0, 1'b1, 32'hC3);
        chk("R3", "rx empty", int'(fifo_empty[0]), 1);
    endtask

    task automatic t_wrap_full();
        push(3, 32'h77);
        for (int i = 0; i < 4; i++) push(2, 16 + i);
        chk("R5", "full at depth", int'(fifo_full[2]), 1);
        push(2, 99);
        chk("R5", "level after full push", lvl(2), 4);
        chk("R5", "err after full push", int'(fifo_err[2]), 1);
        pop_chk("R4", 2, 1'b1, 16);
        pop_chk("R4", 2, 1'b1, 17);
        push(2, 20); push(2, 21);
        for (int i = 0; i < 4; i++) pop_chk("R4", 2, 1'b1, 18 + i);
        chk("R4", "neighbour level", lvl(3), 1);
        pop_chk("R4", 3, 1'b1, 32'h77);
    endtask

    task automatic t_empty_pop();
        pop_chk("R6", 0, 1'b0, 0);
        chk("R6", "err on empty pop", int'(fifo_err[0]), 1);
        chk("R6", "level stays", lvl(0), 0);
    endtask

    task automatic t_cfg_busy();
        push(1, 32'h11);
        cfg(1, 8, 2);
        chk("R2", "err on busy cfg", int'(fifo_err[1]), 1);
        push(1, 32'h12); push(1, 32'h13);
        chk("R2", "depth unchanged not full", int'(fifo_full[1]), 0);
        push(1, 32'h14);
        chk("R2", "full at old depth", int'(fifo_full[1]), 1);
    endtask

    task automatic t_priority();
        push(3, 32'h55);
        @(negedge clk);
        pop_valid = 1'b1; pop_idx = 2'd3;
        push_valid = 1'b1; push_idx = 2'd0; push_data = 32'h66;
        #1;
        chk("R7", "push_ready with pop", int'(push_ready), 0);
        @(negedge clk);
        pop_valid = 1'b0;
        chk("R7", "pop data", int'(rd_data), 32'h55);
        chk("R7", "push stalled", lvl(0), 0);
        #1;
        chk("R7", "push_ready after pop", int'(push_ready), 1);
        @(negedge clk);
        push_valid = 1'b0;
        chk("R7", "push taken late", lvl(0), 1);
    endtask

    task automatic t_flush_one();
        push(3, 32'h31); push(3, 32'h32);
        flush_seq("R8", 1'b1, 0);
        chk("R8", "tx0 emptied", lvl(1), 0);
        chk("R11", "tx0 err cleared", int'(fifo_err[1]), 0);
        chk("R8", "tx2 kept", lvl(3), 2);
        chk("R8", "rx kept", lvl(0), 1);
        chk("R8", "tx1 err kept", int'(fifo_err[2]), 1);
        push(1, 32'h88);
        pop_chk("R8", 1, 1'b1, 32'h88);
    endtask

    task automatic t_flush_all();
        push(1, 32'h41);
        flush_seq("R9", 1'b1, 16);
        chk("R9", "tx0 emptied", lvl(1), 0);
        chk("R9", "tx2 emptied", lvl(3), 0);
        chk("R9", "tx1 err cleared", int'(fifo_err[2]), 0);
        chk("R9", "rx kept", lvl(0), 1);
    endtask

    task automatic t_flush_rx();
        push(2, 32'h51);
        flush_seq("R10", 1'b0, 0);
        chk("R10", "rx emptied", lvl(0), 0);
        chk("R10", "rx err cleared", int'(fifo_err[0]), 0);
        chk("R10", "tx1 kept", lvl(2), 1);
        pop_chk("R10", 2, 1'b1, 32'h51);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cfg_we = 1'b0; cfg_idx = '0; cfg_start = '0; cfg_depth = '0;
        push_valid = 1'b0; push_idx = '0; push_data = '0;
        pop_valid = 1'b0; pop_idx = '0;
        tx_flush_req = 1'b0; tx_flush_num = '0; rx_flush_req = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_config();
        t_order();
        t_wrap_full();
        t_empty_pop();
        t_cfg_busy();
        t_priority();
        t_flush_one();
        t_flush_all();
        t_flush_rx();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule